// File: doc/BRIEF.md
# I2C Master Byte Transmit Sequencer

This block drives an I2C bus as a master that only writes. Software controls it through three small write-only registers: a command register, a data register and a configuration register. Software loads the address byte into the data register and then writes the start command. The block then issues a START condition, shifts the byte out MSB first on eight SCL pulses, and can add a ninth acknowledge clock. After each byte the block holds SCL low. Each new write to the data register sends one more byte.

Software can arm a stop request at any point while a transfer is in progress. When the current byte finishes, the block issues a STOP condition and returns to idle. If the stop request arrives while the block is already parked between bytes, the STOP follows at once. The SCL rate is set by one of two clock dividers (standard or fast). A mode bit adds or removes the acknowledge clock. The acknowledge level sampled on the ninth clock is exposed as a status bit.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o=1, sda_o=1, busy=0, waiting=0 and nack=0. Whenever busy=0, both bus lines stay high.
- R2: Writing the command register (wr_addr=0) with bit 0 set, while the block is idle and enabled, makes SDA fall while SCL is high (START) and raises busy.
- R3: Each byte goes out MSB first, one bit per SCL pulse, and SDA stays constant while SCL is high. In acknowledge mode a ninth pulse follows with sda_o released to 1.
- R4: In acknowledge mode, sda_i is sampled while the ninth SCL pulse is high and stored in nack (1 = not acknowledged). A new START clears nack.
- R5: With the acknowledge-clock bit (cfg bit 1) at 0, exactly eight SCL pulses are produced per byte and nack stays 0.
- R6: When a byte ends with no stop armed, SCL is held low and waiting=1. A write to the data register (wr_addr=1) then sends that byte.
- R7: Writing command bit 1 arms a stop. When the current byte ends, or at once if the block is waiting, SDA rises while SCL is high (STOP) and busy then falls. Writing command bits 0 and 1 together gives a single-byte transfer that ends in STOP.
- R8: The SCL period is 4*DIV_STD clocks with cfg bit 0 at 0, and 4*DIV_FAST clocks with cfg bit 0 at 1.
- R9: While cfg bit 2 (enable) is 0, a start command is ignored and both lines stay high.
- R10: Writes to the configuration register (wr_addr=2) while busy are ignored. So are data-register writes during START, during a byte, or during STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 command, 1 data, 2 configuration |
| wr_data | input | 8 | Write data |
| sda_i | input | 1 | Sampled SDA level from the bus |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level driven (1 = released) |
| busy | output | 1 | High from START until STOP completes |
| waiting | output | 1 | Parked between bytes, SCL held low |
| nack | output | 1 | Last sampled acknowledge bit |

## Verification
Two functions can meet in one write: the start command and the stop request. When software writes both command bits together, the stop arming and the launch of the first byte happen in the same cycle. The sweep provokes this with a single-byte transfer under every speed, acknowledge mode and response level. It judges the result by counting exactly one START, one STOP and the correct bit stream. The same sweep also arms the stop while the last byte is still shifting, so the stop request coincides with an active transfer rather than an idle wait.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_STD  = 250,
  parameter int DIV_FAST = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy,
  output logic       waiting,
  output logic       nack
);
  localparam int DMAX = (DIV_STD > DIV_FAST) ? DIV_STD : DIV_FAST;
  localparam int CW = $clog2(DMAX + 1);
  localparam logic [CW-1:0] LIM_STD  = CW'(DIV_STD - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_WAIT, S_STOP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    shreg;
  logic          fast_q, ackclk_q, en_q, stop_arm;
  logic          running, tick, last_bit, in_xfer, in_stop;
  logic          wr_cmd, wr_dat, wr_cfg, stop_req;

  assign wr_cmd   = wr_en && wr_addr == 2'd0;
  assign wr_dat   = wr_en && wr_addr == 2'd1;
  assign wr_cfg   = wr_en && wr_addr == 2'd2;
  assign stop_req = wr_cmd && wr_data[1];

  assign running  = st == S_START || st == S_XFER || st == S_STOP;
  assign tick     = running && cnt == (fast_q ? LIM_FAST : LIM_STD);
  assign last_bit = bitn == (ackclk_q ? 4'd8 : 4'd7);
  assign busy     = st != S_IDLE;
  assign waiting  = st == S_WAIT;
  assign in_xfer  = st == S_XFER;
  assign in_stop  = st == S_STOP;

  always_comb begin
    scl_o = 1'b1;
    sda_o = 1'b1;
    case (st)
      S_START: begin scl_o = ph == 2'd0;               sda_o = 1'b0; end
      S_XFER:  begin scl_o = ph == 2'd1 || ph == 2'd2; sda_o = bitn == 4'd8 || shreg[7]; end
      S_WAIT:  begin scl_o = 1'b0;                     sda_o = 1'b0; end
      S_STOP:  begin scl_o = ph != 2'd0;               sda_o = ph == 2'd2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ph       <= '0;
      bitn     <= '0;
      shreg    <= '0;
      fast_q   <= 1'b0;
      ackclk_q <= 1'b0;
      en_q     <= 1'b0;
      stop_arm <= 1'b0;
      nack     <= 1'b0;
    end else begin
      cnt <= (tick || !running) ? '0 : cnt + 1'b1;
      if (wr_cfg && st == S_IDLE) {en_q, ackclk_q, fast_q} <= wr_data[2:0];
      if (busy && stop_req) stop_arm <= 1'b1;
      case (st)
        S_IDLE: begin
          stop_arm <= 1'b0;
          if (wr_dat) shreg <= wr_data;
          if (wr_cmd && wr_data[0] && en_q) begin
            st       <= S_START;
            ph       <= '0;
            nack     <= 1'b0;
            stop_arm <= wr_data[1];
          end
        end
        S_START: if (tick) begin
          if (ph == 2'd1) begin
            st   <= S_XFER;
            ph   <= '0;
            bitn <= '0;
          end else ph <= ph + 2'd1;
        end
        S_XFER: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd1 && bitn == 4'd8) nack <= sda_i;
          if (ph == 2'd3) begin
            if (last_bit) st <= (stop_arm || stop_req) ? S_STOP : S_WAIT;
            else begin
              bitn  <= bitn + 4'd1;
              shreg <= {shreg[6:0], 1'b0};
            end
          end
        end
        S_WAIT: begin
          if (wr_dat) begin
            shreg <= wr_data;
            bitn  <= '0;
            ph    <= '0;
            st    <= S_XFER;
          end else if (stop_req) begin
            ph <= '0;
            st <= S_STOP;
          end
        end
        S_STOP: if (tick) begin
          if (ph == 2'd2) begin
            st <= S_IDLE;
            ph <= '0;
          end else ph <= ph + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_o,
  input logic sda_o,
  input logic busy,
  input logic waiting,
  input logic in_xfer,
  input logic in_stop,
  input logic fast_q
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_o && sda_o);                                           // R1
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> scl_o && !sda_o && $past(sda_o) && $past(scl_o));    // R2
  AST_SDA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer && scl_o && $past(scl_o) |-> $stable(sda_o));                // R3
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(in_xfer) && !scl_o);                        // R6
  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(in_stop) && $past(scl_o) && $past(sda_o));     // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fast_q));                            // R10
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
  .waiting(waiting), .in_xfer(in_xfer), .in_stop(in_stop), .fast_q(fast_q)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int DS = 6;
  localparam int DF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sda_i = 1'b0;
  logic       scl_o, sda_o, busy, waiting, nack;

  always #4 clk = ~clk;

  i2c_byte_master #(.DIV_STD(DS), .DIV_FAST(DF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .waiting(waiting), .nack(nack)
  );

  int n_chk = 0, n_fail = 0;
  int starts, stops, nbits, cyc = 0;
  int rise_t0, rise_t1;
  logic [63:0] cap;
  logic pscl = 1'b1, psda = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (scl_o && pscl && psda && !sda_o) starts++;
      if (scl_o && pscl && !psda && sda_o) begin
        stops++;
        nbits--;
        cap = cap >> 1;
      end
      if (scl_o && !pscl) begin
        if (nbits == 0) rise_t0 = cyc;
        if (nbits == 1) rise_t1 = cyc;
        cap = {cap[62:0], sda_o};
        nbits++;
      end
    end
    pscl = scl_o;
    psda = sda_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_waiting();
    for (int k = 0; k < 5000 && !waiting; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  function automatic logic [7:0] bval(input int b, input int tag);
    logic [7:0] v;
    v = 8'(tag * 37 + b * 91 + 8'h5A);
    return (b == 0) ? {v[6:0], 1'b0} : v;
  endfunction

  task automatic run(input bit fast, input bit ack, input int nb, input bit nl, input int mode, input int tag);
    logic [63:0] e;
    int eb;
    logic [7:0] v;
    sda_i = nl;
    wr(2'd2, {5'b0, 1'b1, ack, fast});
    starts = 0; stops = 0; nbits = 0; cap = '0;
    e = '0; eb = 0;
    for (int b = 0; b < nb; b++) begin
      v = bval(b, tag);
      for (int i = 7; i >= 0; i--) begin e = {e[62:0], v[i]}; eb++; end
      if (ack) begin e = {e[62:0], 1'b1}; eb++; end
    end
    wr(2'd1, bval(0, tag));
    wr(2'd0, (mode == 2) ? 8'h03 : 8'h01);
    chk(busy, "R2 busy after start", busy, 1);
    wr(2'd1, 8'hFF);
    wr(2'd2, {5'b0, 1'b1, ack, ~fast});
    if (mode == 1 && nb == 1) wr(2'd0, 8'h02);
    for (int b = 1; b < nb; b++) begin
      wait_waiting();
      chk(waiting && !scl_o, "R6 parked with SCL low", scl_o, 0);
      chk(nack == (ack & nl), "R4 nack after byte", nack, ack & nl);
      wr(2'd1, bval(b, tag));
      if (mode == 1 && b == nb - 1) wr(2'd0, 8'h02);
    end
    if (mode == 0) begin
      wait_waiting();
      chk(waiting && !scl_o && busy, "R6 parked before stop", waiting, 1);
      wr(2'd0, 8'h02);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk(starts == 1, "R2 start count", starts, 1);
    chk(stops == 1, "R7 stop count", stops, 1);
    chk(!busy && scl_o && sda_o, "R7 idle after stop", busy, 0);
    chk(nbits == eb, ack ? "R3 pulses per transfer" : "R5 pulses per transfer", nbits, eb);
    chk(cap == e, "R3 bit stream", cap, e);
    chk(rise_t1 - rise_t0 == 4 * (fast ? DF : DS), "R8 SCL period / R10 cfg ignored",
        rise_t1 - rise_t0, 4 * (fast ? DF : DS));
    chk(nack == (ack & nl), ack ? "R4 final nack" : "R5 nack stays 0", nack, ack & nl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int tag;
    tag = 0;
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o && !busy && !waiting && !nack, "R1 reset state",
        {scl_o, sda_o, busy, waiting, nack}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    repeat (20) @(negedge clk);
    chk(!busy && scl_o && sda_o, "R9 start ignored when disabled", busy, 0);
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 2; a++)
        for (int l = 0; l < 2; l++)
          for (int n = 1; n <= 3; n++)
            for (int m = 0; m < 3; m++)
              if (m != 2 || n == 1) begin
                run(f[0], a[0], n, l[0], m, tag);
                tag++;
              end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule